// File: doc/BRIEF.md
# Beacon and Timestamp Synchronization Timer

This block keeps time for a wireless MAC. It divides the core clock into a 1 microsecond tick and then into a 64 microsecond tick, which is one sixteenth of a 1024 microsecond time unit. The microsecond tick advances a 64-bit station timestamp counter. The 64 microsecond tick drives a beacon down-timer. The first countdown of that timer uses a separate preload value. After that, the timer reloads from the beacon interval in the same cycle that it expires, so the expiry period never drifts.

Software uses a small word-addressed register port. A write takes effect at the clock edge that samples it. A read returns data in `reg_rdata` after the edge that samples `reg_rd`, and the value stays there until the next read. A beacon expiry sets a sticky status bit, which software clears by writing 1. A mask bit keeps the status from reaching the `irq` output. Reading the low timestamp word captures the high word, so a 64-bit value read as two words is consistent.

Register map (word address, fields):
- 0, control: bit 0 timestamp run, bit 1 beacon enable, bits 3:2 sync mode (0 off, 1 infrastructure, 2 ad-hoc/master).
- 1, timebase: bits 7:0 clocks per microsecond, bits 15:8 microseconds per 64 microsecond tick.
- 2, beacon configuration: bits 15:0 interval, bits 31:16 first-expiry preload, both in 64 microsecond units.
- 3, timestamp low word.
- 4, timestamp high word.
- 5, status: bit 0 beacon expired, write 1 to clear.
- 6, mask: bit 0, where 1 blocks the interrupt.
- 7, remaining beacon count (read only).

Top module: `beacon_tsf_timer`

## Requirements
- R1: After reset:
  - control reads 0.
  - Timebase reads 0x4008 (8 clocks per microsecond, 64 microseconds per tick).
  - Beacon configuration reads 0x06400640 (100 time units for both fields).
  - The timestamp reads 0, status reads 0, and `irq` is low.
- R2: While control bit 0 is 1, the timestamp increases by one on every microsecond tick, and while it is 0 the timestamp holds. A microsecond tick occurs once every N core clocks, where N is timebase bits 7:0. A value of 0 is treated as 1.
- R3: A 64 microsecond tick occurs once every M microsecond ticks, where M is timebase bits 15:8 (0 is treated as 1). Both prescalers restart from zero whenever control bits 0 and 1 are both clear.
- R4: Beacon countdown:
  - A control write that changes bit 1 from 0 to 1 loads the preload value.
  - The first expiry happens on the preload-th 64 microsecond tick, and a preload of 0 expires on the first tick.
  - After that, an expiry happens every interval ticks, with the interval reloaded in the expiry cycle.
- R5: A read of address 3 returns the low timestamp word and captures the high word. A read of address 4 returns that captured word.
- R6: A write to address 3 or 4 replaces that half of the timestamp, and the write takes priority over counting in that cycle.
- R7: A beacon expiry sets status bit 0, and writing 1 to it clears it. An expiry in the same cycle as a clear write leaves the bit set.
- R8: `irq` is high exactly when status bit 0 is 1 and mask bit 0 is 0. A masked status still reads back as 1.
- R9: Control bits 3:2 store the sync mode and read back unchanged.
- R10: Address 7 reads the current beacon down-count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid after the sampling edge |
| irq | output | 1 | Unmasked beacon-expired interrupt |

## Verification
The in-line properties assume that reset is applied before any traffic, and that at most one of the two timestamp halves is written per cycle, which the single address port guarantees. The exact-cycle expectations also assume that timebase and beacon values are reprogrammed only while both counting enables are clear. The directed stimulus therefore writes every ratio, interval and preload before it sets a run or enable bit. It switches counting off before it reads a count that must be exact, and it places the clear write of the collision case on the exact edge where the computed expiry falls.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL  = 3'd0,
    A_TBASE = 3'd1,
    A_BCFG  = 3'd2,
    A_TSFL  = 3'd3,
    A_TSFH  = 3'd4,
    A_STAT  = 3'd5,
    A_MASK  = 3'd6,
    A_BCNT  = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_BCN_BIT  = 1;
  localparam int unsigned CTRL_SYNC_LSB = 2;
  localparam int unsigned SYNC_W        = 2;
endpackage

// File: rtl/bts_prescaler.sv
module bts_prescaler #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick_in,
  input  logic [W-1:0] ratio,
  output logic         tick_out
);
  logic [W-1:0] cnt;
  logic         last;

  assign last     = (ratio == '0) ? 1'b1 : (cnt >= ratio - 1'b1);
  assign tick_out = en & tick_in & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (tick_in) cnt <= last ? '0 : cnt + 1'b1;
  end

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> (cnt == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick_in) |=> $stable(cnt));
endmodule

// File: rtl/bts_tsf_counter.sv
module bts_tsf_counter #(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              us_tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic [2*HALF_W-1:0] tsf
);
  localparam int unsigned TSF_W = 2 * HALF_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsf <= '0;
    end else if (wr_lo) begin
      tsf[HALF_W-1:0] <= wdata;
    end else if (wr_hi) begin
      tsf[TSF_W-1:HALF_W] <= wdata;
    end else if (run && us_tick) begin
      tsf <= tsf + 1'b1;
    end
  end

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && us_tick && !wr_lo && !wr_hi) |=> (tsf == $past(tsf) + 1'b1));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && us_tick) && !wr_lo && !wr_hi) |=> $stable(tsf));
  // R6
  wr_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (tsf[HALF_W-1:0] == $past(wdata)));
endmodule

// File: rtl/bts_beacon_timer.sv
module bts_beacon_timer #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_RST = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic             t64_tick,
  input  logic [CNT_W-1:0] preload,
  input  logic [CNT_W-1:0] interval,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  assign expire = en & t64_tick & !load & (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= CNT_RST;
    else if (load)             cnt <= preload;
    else if (en && t64_tick)   cnt <= expire ? interval : cnt - 1'b1;
  end

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == $past(interval)));
  // R4
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(preload)));
  // R4
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expire) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/bts_irq.sv
module bts_irq #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] stat,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_bits : '0;
  assign irq     = |(stat & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '0;
    end else begin
      stat <= (stat & ~clr_eff) | set_evt;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt[0] |=> stat[0]);
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_bits[0] && !set_evt[0]) |=> !stat[0]);
  // R8
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
endmodule

// File: rtl/beacon_tsf_timer.sv
module beacon_tsf_timer
  import bts_pkg::*;
#(
  parameter int unsigned TB_W            = 8,
  parameter int unsigned BI_W            = 16,
  parameter int unsigned CLK_PER_US_RST  = 8,
  parameter int unsigned US_PER_T64_RST  = 64,
  parameter int unsigned BCN_INTV_RST    = 1600,
  parameter int unsigned BCN_PRELOAD_RST = 1600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq
);
  localparam int unsigned HALF_W  = DATA_W;
  localparam int unsigned TSF_W   = 2 * HALF_W;
  localparam int unsigned NSTAGE  = 2;

  logic                 ctrl_run, ctrl_bcn;
  logic [SYNC_W-1:0]    sync_mode;
  logic [TB_W-1:0]      ratio [NSTAGE];
  logic [BI_W-1:0]      bcn_intv, bcn_pre, bcn_cnt;
  logic [HALF_W-1:0]    hi_shadow;
  logic [TSF_W-1:0]     tsf;
  logic [NSTAGE:0]      tick_chain;
  logic                 pre_en, bcn_load, expire;
  logic [0:0]           stat, mask;
  logic [DATA_W-1:0]    rd_word;
  reg_addr_e            addr;

  assign addr = reg_addr_e'(reg_addr);

  wire wr_ctrl = reg_wr && (addr == A_CTRL);
  wire wr_tb   = reg_wr && (addr == A_TBASE);
  wire wr_bcfg = reg_wr && (addr == A_BCFG);
  wire wr_tsfl = reg_wr && (addr == A_TSFL);
  wire wr_tsfh = reg_wr && (addr == A_TSFH);
  wire wr_stat = reg_wr && (addr == A_STAT);
  wire wr_mask = reg_wr && (addr == A_MASK);

  assign bcn_load = wr_ctrl && reg_wdata[CTRL_BCN_BIT] && !ctrl_bcn;
  assign pre_en   = ctrl_run | ctrl_bcn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_run  <= 1'b0;
      ctrl_bcn  <= 1'b0;
      sync_mode <= '0;
      ratio[0]  <= TB_W'(CLK_PER_US_RST);
      ratio[1]  <= TB_W'(US_PER_T64_RST);
      bcn_intv  <= BI_W'(BCN_INTV_RST);
      bcn_pre   <= BI_W'(BCN_PRELOAD_RST);
    end else begin
      if (wr_ctrl) begin
        ctrl_run  <= reg_wdata[CTRL_RUN_BIT];
        ctrl_bcn  <= reg_wdata[CTRL_BCN_BIT];
        sync_mode <= reg_wdata[CTRL_SYNC_LSB +: SYNC_W];
      end
      if (wr_tb) begin
        ratio[0] <= reg_wdata[0 +: TB_W];
        ratio[1] <= reg_wdata[TB_W +: TB_W];
      end
      if (wr_bcfg) begin
        bcn_intv <= reg_wdata[0 +: BI_W];
        bcn_pre  <= reg_wdata[BI_W +: BI_W];
      end
    end
  end

  // Timebase: stage 0 makes the microsecond tick, stage 1 the 64 us tick.
  assign tick_chain[0] = 1'b1;
  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    bts_prescaler #(.W(TB_W)) i_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pre_en),
      .tick_in  (tick_chain[s]),
      .ratio    (ratio[s]),
      .tick_out (tick_chain[s+1])
    );
  end

  bts_tsf_counter #(.HALF_W(HALF_W)) i_tsf (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_run),
    .us_tick (tick_chain[1]),
    .wr_lo   (wr_tsfl),
    .wr_hi   (wr_tsfh),
    .wdata   (reg_wdata),
    .tsf     (tsf)
  );

  bts_beacon_timer #(.CNT_W(BI_W), .CNT_RST(BI_W'(BCN_PRELOAD_RST))) i_bcn (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_bcn),
    .load     (bcn_load),
    .t64_tick (tick_chain[NSTAGE]),
    .preload  (bcn_pre),
    .interval (bcn_intv),
    .expire   (expire),
    .cnt      (bcn_cnt)
  );

  bts_irq #(.N(1)) i_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_evt    (expire),
    .clr_wr     (wr_stat),
    .clr_bits   (reg_wdata[0]),
    .mask_wr    (wr_mask),
    .mask_wdata (reg_wdata[0]),
    .stat       (stat),
    .mask       (mask),
    .irq        (irq)
  );

  always_comb begin
    rd_word = '0;
    unique case (addr)
      A_CTRL: begin
        rd_word[CTRL_RUN_BIT] = ctrl_run;
        rd_word[CTRL_BCN_BIT] = ctrl_bcn;
        rd_word[CTRL_SYNC_LSB +: SYNC_W] = sync_mode;
      end
      A_TBASE: begin
        rd_word[0 +: TB_W]    = ratio[0];
        rd_word[TB_W +: TB_W] = ratio[1];
      end
      A_BCFG: begin
        rd_word[0 +: BI_W]    = bcn_intv;
        rd_word[BI_W +: BI_W] = bcn_pre;
      end
      A_TSFL: rd_word = tsf[HALF_W-1:0];
      A_TSFH: rd_word = hi_shadow;
      A_STAT: rd_word[0] = stat[0];
      A_MASK: rd_word[0] = mask[0];
      A_BCNT: rd_word[0 +: BI_W] = bcn_cnt;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      hi_shadow <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_word;
      if (addr == A_TSFL) hi_shadow <= tsf[TSF_W-1:HALF_W];
    end
  end

  // R5
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && addr == A_TSFL) |=> (hi_shadow == $past(tsf[TSF_W-1:HALF_W])));
  // R5
  hi_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && addr == A_TSFH) |=> (reg_rdata == $past(hi_shadow)));
  // R4
  load_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcn_load |=> ctrl_bcn);
endmodule

// File: tb/test_beacon_tsf_timer.sv
module test_beacon_tsf_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  beacon_tsf_timer i_beacon_tsf_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  localparam logic [2:0] CTRL = 3'd0, TBASE = 3'd1, BCFG = 3'd2, TSFL = 3'd3,
                         TSFH = 3'd4, STAT = 3'd5, MASK = 3'd6, BCNT = 3'd7;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(TBASE, v); chk("R1 timebase", v, 32'h0000_4008);
    rd(BCFG, v);  chk("R1 beacon cfg", v, 32'h0640_0640);
    rd(TSFL, v);  chk("R1 tsf low", v, 32'h0);
    rd(STAT, v);  chk("R1 status", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_sync;
    logic [31:0] v;
    wr(CTRL, 32'h0000_000C);
    rd(CTRL, v); chk("R9 sync mode readback", v, 32'h0000_000C);
    wr(CTRL, 32'h0000_0004);
    rd(CTRL, v); chk("R9 sync mode infra", v, 32'h0000_0004);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_tsf_count;
    logic [31:0] v;
    wr(TSFL, 32'h0);
    wr(TSFH, 32'h0);
    wr(TBASE, 32'h0000_0204);   // 4 clocks per us
    wr(CTRL, 32'h1);            // run from edge E0
    skip(39);
    wr(CTRL, 32'h0);            // sampled at E40: 10 us ticks
    rd(TSFL, v); chk("R2 tsf after 40 clocks at N=4", v, 32'd10);
    skip(8);
    rd(TSFL, v); chk("R2 tsf holds while stopped", v, 32'd10);
    wr(TBASE, 32'h0000_0200);   // N=0 acts as 1
    wr(CTRL, 32'h1);
    skip(19);
    wr(CTRL, 32'h0);            // 20 more ticks
    rd(TSFL, v); chk("R2 zero ratio counts each clock", v, 32'd30);
  endtask

  task automatic t_tsf_latch;
    logic [31:0] v;
    wr(TBASE, 32'h0000_0101);
    wr(TSFH, 32'h0000_0005);
    wr(TSFL, 32'hFFFF_FFF0);
    rd(TSFL, v); chk("R6 low word write", v, 32'hFFFF_FFF0);
    wr(CTRL, 32'h1);
    skip(29);
    wr(CTRL, 32'h0);            // 30 ticks: carries into high word
    rd(TSFH, v); chk("R5 high word captured at low read", v, 32'h0000_0005);
    rd(TSFL, v); chk("R5 low word after carry", v, 32'h0000_000E);
    rd(TSFH, v); chk("R5 high word after new low read", v, 32'h0000_0006);
  endtask

  task automatic t_beacon;
    logic [31:0] v;
    wr(TBASE, 32'h0000_0202);   // 64 us tick every 4 clocks
    wr(BCFG, 32'h0003_0005);    // preload 3, interval 5
    wr(CTRL, 32'h2);            // E0: load preload
    skip(11);
    chk("R4 no expiry before third tick", {31'b0, irq}, 32'h0);
    skip(1);
    chk("R4 first expiry at preload (E12)", {31'b0, irq}, 32'h1);
    rd(BCNT, v); chk("R10 count reloaded to interval", v, 32'd5);
    wr(STAT, 32'h1);            // E14 clear
    chk("R7 write one clears status", {31'b0, irq}, 32'h0);
    skip(17);
    chk("R4 no expiry before interval", {31'b0, irq}, 32'h0);
    skip(1);
    chk("R4 second expiry after interval (E32)", {31'b0, irq}, 32'h1);
    wr(STAT, 32'h1);
    skip(18);
    wr(STAT, 32'h1);            // sampled at E52, same edge as expiry
    chk("R7 expiry wins against clear", {31'b0, irq}, 32'h1);
    wr(MASK, 32'h1);
    chk("R8 mask blocks irq", {31'b0, irq}, 32'h0);
    rd(STAT, v); chk("R8 masked status still set", v, 32'h1);
    wr(MASK, 32'h0);
    chk("R8 unmask restores irq", {31'b0, irq}, 32'h1);
    wr(STAT, 32'h1);
    wr(CTRL, 32'h0);
    chk("R7 cleared before next test", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_zero_preload;
    wr(TBASE, 32'h0000_0101);   // 64 us tick every clock
    wr(BCFG, 32'h0000_0002);    // preload 0, interval 2
    wr(CTRL, 32'h2);            // E0
    skip(1);
    chk("R4 zero preload expires on first tick", {31'b0, irq}, 32'h1);
    wr(STAT, 32'h1);            // E2
    chk("R3 status clear between ticks", {31'b0, irq}, 32'h0);
    skip(1);
    chk("R3 interval 2 expiry at E3", {31'b0, irq}, 32'h1);
    wr(CTRL, 32'h0);
    wr(STAT, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    skip(2);
    t_reset();
    t_sync();
    t_tsf_count();
    t_tsf_latch();
    t_beacon();
    t_zero_preload();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule